// File: doc/BRIEF.md
# GPIO Bank External-Interrupt Unit

This block turns up to 32 GPIO input lines of one bank into interrupt events. Each line has its own trigger mode: rising edge, falling edge, both edges, high level or low level. A line can raise an event only while its pin-function select equals the external-interrupt function code. Events land in a sticky pending register. Software clears a pending bit by writing a 1 to it. Pending bits that are also enabled are ORed into one registered interrupt request.

Software reaches the unit through a single-cycle 32-bit register port. The port carries a byte address into the controller's map. Bank `BANK_IDX` answers inside a 32-byte window that starts at 0x200 + 0x20*`BANK_IDX`. The window holds four configuration words, an enable word, the pending word and a sample-rate control word. Pin inputs pass through a two-flop synchronizer. They are then sampled at a programmable rate before any edge or level is judged.

Top module: `gpio_eint_bank`

## Requirements
- R1: After reset every register in the window reads 0 and `irq_o` is 0.
- R2: The configuration slot of line n is 4 bits wide. It lives in the word at window offset 4*(n/8), bits 4*(n%8)+3 down to 4*(n%8). All 4 bits read back as written, and the low 3 bits are the trigger mode.
- R3: Mode 0 detects a rising edge, mode 1 a falling edge and mode 4 either edge. With sample rate 0, a pin change driven before clock edge k shows as pending after edge k+3.
- R4: Mode 2 triggers while the sampled pin is high, and mode 3 while it is low. If software clears a pending bit while its level is still active, the bit reads 0 right after the clearing write and reads 1 again one cycle later.
- R5: Mode codes 5, 6 and 7 never set a pending bit.
- R6: The pending word sits at offset 0x14. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. A pending bit stays set until it is cleared.
- R7: A line sets its pending bit only while its 3-bit function select equals `EINT_FUNC` (default 6). With any other select, such as 0 or 1, it never sets.
- R8: The enable word sits at offset 0x10, with bit n for line n. Pending bits latch whether or not they are enabled. `irq_o` is the OR over all lines of pending AND enable, registered one cycle.
- R9: The word at offset 0x18 holds a 3-bit sample-rate select p in bits 6:4. Its other bits read 0. Pins are sampled every 2^p clocks, and a write to this word restarts the sampling phase. With p=2, a rising pin set right after the write shows as pending after the 6th clock edge past the write.
- R10: Accesses outside the bank's window, and offset 0x1C inside it, write nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access in this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address in the controller map |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the access cycle |
| pin_in | input | NUM_LINES | Asynchronous pin levels |
| pin_func | input | NUM_LINES*FUNC_W | Function select of each line, line n at bits FUNC_W*n upward |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Each result has its own latency. A register read returns in the same cycle. A pin change driven between edges becomes pending at the fourth edge when the sample rate is 0. The request output follows the pending and enable bits one edge later. A re-armed level bit returns one edge after the clearing write. With sample rate 2, a rising pin is due at the sixth edge after that write. The bench drives every stimulus at a falling edge and waits an exact number of falling edges before it reads. It checks each timing-critical result once at the cycle before it is due, where the value must still be old, and once at the due cycle. Read expectations go through a queue and are compared when the read is on the bus.

// File: rtl/gpio_eint_pkg.sv
`timescale 1ns/1ps
package gpio_eint_pkg;
  localparam int SLOT_W         = 4;
  localparam int SLOTS_PER_WORD = 8;
  localparam int PS_W           = 3;
  localparam int CNT_W          = (1 << PS_W) - 1;
  localparam int DB_LSB         = 4;

  typedef enum logic [2:0] {
    EM_RISE = 3'd0,
    EM_FALL = 3'd1,
    EM_HIGH = 3'd2,
    EM_LOW  = 3'd3,
    EM_BOTH = 3'd4
  } eint_mode_e;

  // word index inside the 32-byte bank window
  localparam logic [2:0] WIDX_EN = 3'd4;
  localparam logic [2:0] WIDX_ST = 3'd5;
  localparam logic [2:0] WIDX_DB = 3'd6;

  function automatic logic edge_hit(input logic [2:0] mode, input logic cur, input logic prv);
    case (mode)
      EM_RISE: return cur & ~prv;
      EM_FALL: return ~cur & prv;
      EM_BOTH: return cur ^ prv;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic level_hit(input logic [2:0] mode, input logic cur);
    case (mode)
      EM_HIGH: return cur;
      EM_LOW:  return ~cur;
      default: return 1'b0;
    endcase
  endfunction

  // a sample is taken when the low ps bits of the phase counter are zero
  function automatic logic tick_due(input logic [CNT_W-1:0] cnt, input logic [PS_W-1:0] ps);
    logic [CNT_W-1:0] mask;
    mask = CNT_W'((8'd1 << ps) - 8'd1);
    return (cnt & mask) == '0;
  endfunction
endpackage

// File: rtl/eint_sampler.sv
`timescale 1ns/1ps
module eint_sampler
  import gpio_eint_pkg::*;
#(
  parameter int N = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    pin_in,
  input  logic [PS_W-1:0] ps,
  input  logic            restart,
  output logic [N-1:0]    cur_o,
  output logic [N-1:0]    prv_o,
  output logic            fresh_o
);
  logic [N-1:0]     sync1, sync2;
  logic [CNT_W-1:0] phase;
  logic             tick;

  assign tick = tick_due(phase, ps);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      phase   <= '0;
      cur_o   <= '0;
      prv_o   <= '0;
      fresh_o <= 1'b0;
    end else begin
      sync1   <= pin_in;
      sync2   <= sync1;
      phase   <= restart ? '0 : phase + 1'b1;
      fresh_o <= tick;
      if (tick) begin
        cur_o <= sync2;
        prv_o <= cur_o;
      end
    end
  end
endmodule

// File: rtl/eint_detect.sv
`timescale 1ns/1ps
module eint_detect
  import gpio_eint_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N*SLOT_W-1:0] slots,
  input  logic [N-1:0]        cur,
  input  logic [N-1:0]        prv,
  input  logic [N-1:0]        func_ok,
  input  logic                fresh,
  output logic [N-1:0]        edge_set,
  output logic [N-1:0]        level_set
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [2:0] mode;
    assign mode         = slots[i*SLOT_W +: 3];
    assign edge_set[i]  = func_ok[i] & fresh & edge_hit(mode, cur[i], prv[i]);
    assign level_set[i] = func_ok[i] & level_hit(mode, cur[i]);
  end
endmodule

// File: rtl/eint_regs.sv
`timescale 1ns/1ps
module eint_regs
  import gpio_eint_pkg::*;
#(
  parameter int N        = 32,
  parameter int ADDR_W   = 12,
  parameter int BANK_IDX = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_sel,
  input  logic                acc_wr,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [31:0]         acc_wdata,
  output logic [31:0]         acc_rdata,
  input  logic [N-1:0]        edge_set,
  input  logic [N-1:0]        level_set,
  output logic [N*SLOT_W-1:0] slots,
  output logic [N-1:0]        enable_q,
  output logic [N-1:0]        status_q,
  output logic [N-1:0]        clr_vec,
  output logic [PS_W-1:0]     ps_q,
  output logic                ps_restart,
  output logic                hit
);
  localparam int WIN_W     = ADDR_W - 5;
  localparam int BANK_SLOT = (32'h200 >> 5) + BANK_IDX;

  logic [2:0] widx;
  logic       wr_en;

  assign widx       = acc_addr[4:2];
  assign hit        = acc_addr[ADDR_W-1:5] == WIN_W'(BANK_SLOT);
  assign wr_en      = acc_sel & acc_wr & hit;
  assign clr_vec    = (wr_en && widx == WIDX_ST) ? acc_wdata[N-1:0] : '0;
  assign ps_restart = wr_en && widx == WIDX_DB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots    <= '0;
      enable_q <= '0;
      status_q <= '0;
      ps_q     <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wr_en && widx == 3'(i / SLOTS_PER_WORD))
          slots[i*SLOT_W +: SLOT_W] <= acc_wdata[(i % SLOTS_PER_WORD)*SLOT_W +: SLOT_W];
      end
      if (wr_en && widx == WIDX_EN) enable_q <= acc_wdata[N-1:0];
      if (ps_restart) ps_q <= acc_wdata[DB_LSB +: PS_W];
      // edges win over a same-cycle clear, levels re-arm one cycle later
      status_q <= (status_q & ~clr_vec) | edge_set | (level_set & ~clr_vec);
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (acc_sel && !acc_wr && hit) begin
      case (widx)
        WIDX_EN: acc_rdata[N-1:0] = enable_q;
        WIDX_ST: acc_rdata[N-1:0] = status_q;
        WIDX_DB: acc_rdata[DB_LSB +: PS_W] = ps_q;
        default: begin
          for (int i = 0; i < N; i++) begin
            if (widx == 3'(i / SLOTS_PER_WORD))
              acc_rdata[(i % SLOTS_PER_WORD)*SLOT_W +: SLOT_W] = slots[i*SLOT_W +: SLOT_W];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/gpio_eint_bank.sv
`timescale 1ns/1ps
module gpio_eint_bank
  import gpio_eint_pkg::*;
#(
  parameter int          NUM_LINES = 32,
  parameter int          ADDR_W    = 12,
  parameter int          BANK_IDX  = 2,
  parameter int          FUNC_W    = 3,
  parameter int unsigned EINT_FUNC = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_sel,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  input  logic [NUM_LINES-1:0]        pin_in,
  input  logic [NUM_LINES*FUNC_W-1:0] pin_func,
  output logic                        irq_o
);
  logic [NUM_LINES*SLOT_W-1:0] slots;
  logic [NUM_LINES-1:0]        enable_q, status_q, clr_vec;
  logic [NUM_LINES-1:0]        cur, prv, func_ok, edge_set, level_set;
  logic [PS_W-1:0]             ps_q;
  logic                        ps_restart, fresh, win_hit;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_func
    assign func_ok[i] = pin_func[i*FUNC_W +: FUNC_W] == FUNC_W'(EINT_FUNC);
  end

  eint_sampler #(.N(NUM_LINES)) u_smp (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .ps(ps_q), .restart(ps_restart),
    .cur_o(cur), .prv_o(prv), .fresh_o(fresh)
  );

  eint_detect #(.N(NUM_LINES)) u_det (
    .slots(slots), .cur(cur), .prv(prv), .func_ok(func_ok), .fresh(fresh),
    .edge_set(edge_set), .level_set(level_set)
  );

  eint_regs #(.N(NUM_LINES), .ADDR_W(ADDR_W), .BANK_IDX(BANK_IDX)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc_sel(reg_sel), .acc_wr(reg_wr), .acc_addr(reg_addr),
    .acc_wdata(reg_wdata), .acc_rdata(reg_rdata), .edge_set(edge_set),
    .level_set(level_set), .slots(slots), .enable_q(enable_q), .status_q(status_q),
    .clr_vec(clr_vec), .ps_q(ps_q), .ps_restart(ps_restart), .hit(win_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(status_q & enable_q);
  end
endmodule

// File: rtl/gpio_eint_chk.sv
`timescale 1ns/1ps
module gpio_eint_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] status,
  input logic [N-1:0] enable,
  input logic [N-1:0] func_ok,
  input logic [N-1:0] edge_set,
  input logic [N-1:0] clr_vec,
  input logic         acc_sel,
  input logic         acc_wr,
  input logic         win_hit,
  input logic         irq
);
  // R7
  func_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~$past(status) & ~$past(func_ok)) == '0);

  // R8
  irq_combine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|($past(status & enable))));

  // R6
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & $past(clr_vec & ~edge_set)) == '0);

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status) & ~status & ~$past(clr_vec)) == '0);

  // R10
  bank_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_sel & acc_wr & ~win_hit) |-> $stable(enable));
endmodule

bind gpio_eint_bank gpio_eint_chk #(.N(NUM_LINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .status(status_q), .enable(enable_q), .func_ok(func_ok),
  .edge_set(edge_set), .clr_vec(clr_vec), .acc_sel(reg_sel), .acc_wr(reg_wr),
  .win_hit(win_hit), .irq(irq_o)
);

// File: tb/gpio_eint_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_eint_bank_tb_top;
  localparam int NL = 32;
  localparam int FW = 3;
  localparam logic [11:0] BASE = 12'h240;   // bank 2 window
  localparam logic [11:0] O_EN = 12'h10, O_ST = 12'h14, O_DB = 12'h18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_sel = 1'b0, reg_wr = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  logic [NL-1:0] pins = '0;
  logic [NL*FW-1:0] pin_func;
  logic          irq_o;

  always #2.5 clk = ~clk;

  gpio_eint_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pins), .pin_func(pin_func),
    .irq_o(irq_o)
  );

  typedef struct { string tag; logic [31:0] exp; } exp_t;
  exp_t sbq[$];
  int n_chk = 0, n_bad = 0;

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    sbq.push_back('{tag: tag, exp: e});
    @(negedge clk);
    reg_sel = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_chk++;
    if (irq_o !== e) begin
      n_bad++;
      $display("FAIL %s: irq_o=%0b expected=%0b", tag, irq_o, e);
    end
  endtask

  task automatic set_func(input int line, input logic [FW-1:0] v);
    pin_func[line*FW +: FW] = v;
  endtask

  // monitor: compare read data against the queued expectation
  initial begin : monitor
    exp_t it;
    forever begin
      @(negedge clk);
      #1;
      if (reg_sel && !reg_wr) begin
        n_chk++;
        if (sbq.size() == 0) begin
          n_bad++;
          $display("FAIL scoreboard: read with no expectation, actual=%h expected=none", reg_rdata);
        end else begin
          it = sbq.pop_front();
          if (reg_rdata !== it.exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, reg_rdata, it.exp);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < NL; i++) pin_func[i*FW +: FW] = 3'd6;
    set_func(9, 3'd0);
    set_func(10, 3'd1);
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int o = 0; o < 32; o += 4) rd(BASE + 12'(o), 32'h0, "R1 reset read");
    chk_irq(1'b0, "R1 reset irq");

    // R3 default rising mode on lines 1 and 3, then clear all
    pins[1] = 1'b1; pins[3] = 1'b1;
    idle(6);
    rd(BASE + O_ST, 32'h0000_000A, "R3 default rising");
    wr(BASE + O_ST, 32'hFFFF_FFFF);
    rd(BASE + O_ST, 32'h0, "R6 clear all");

    // R2 config layout and readback
    wr(BASE + 12'h00, 32'h0854_3210);
    wr(BASE + 12'h04, 32'hC000_0000);
    wr(BASE + 12'h0C, 32'h8765_4210);
    rd(BASE + 12'h00, 32'h0854_3210, "R2 word0");
    rd(BASE + 12'h04, 32'hC000_0000, "R2 word1");
    rd(BASE + 12'h08, 32'h0, "R2 word2");
    rd(BASE + 12'h0C, 32'h8765_4210, "R2 word3");

    // R3 rising latency on line 0
    pins[0] = 1'b1;
    idle(3);
    rd(BASE + O_ST, 32'h0, "R3 rise before due");
    rd(BASE + O_ST, 32'h1, "R3 rise due");
    wr(BASE + O_ST, 32'h1);
    rd(BASE + O_ST, 32'h0, "R6 clear one");

    // R3 falling on line 1, R6 write of zero
    pins[1] = 1'b0;
    idle(6);
    rd(BASE + O_ST, 32'h2, "R3 falling");
    wr(BASE + O_ST, 32'h0);
    rd(BASE + O_ST, 32'h2, "R6 zero write keeps");
    wr(BASE + O_ST, 32'h2);
    rd(BASE + O_ST, 32'h0, "R6 clear falling");

    // R3 both edges on line 4
    pins[4] = 1'b1;
    idle(6);
    rd(BASE + O_ST, 32'h10, "R3 both rise");
    wr(BASE + O_ST, 32'h10);
    pins[4] = 1'b0;
    idle(6);
    rd(BASE + O_ST, 32'h10, "R3 both fall");
    wr(BASE + O_ST, 32'h10);

    // R5 reserved mode on line 5
    pins[5] = 1'b1;
    idle(6);
    pins[5] = 1'b0;
    idle(6);
    rd(BASE + O_ST, 32'h0, "R5 reserved mode");

    // R4 high level on line 2 with re-arm
    pins[2] = 1'b1;
    idle(6);
    rd(BASE + O_ST, 32'h4, "R4 high level");
    wr(BASE + O_ST, 32'h4);
    rd(BASE + O_ST, 32'h0, "R4 cleared after write");
    rd(BASE + O_ST, 32'h4, "R4 re-armed");
    pins[2] = 1'b0;
    idle(6);
    wr(BASE + O_ST, 32'h4);
    rd(BASE + O_ST, 32'h0, "R4 high released");

    // R4 low level on line 3
    pins[3] = 1'b0;
    idle(6);
    rd(BASE + O_ST, 32'h8, "R4 low level");
    pins[3] = 1'b1;
    idle(6);
    wr(BASE + O_ST, 32'h8);
    rd(BASE + O_ST, 32'h0, "R4 low released");

    // R7 function gating on line 9
    pins[9] = 1'b1;
    idle(6);
    rd(BASE + O_ST, 32'h0, "R7 wrong function");
    set_func(9, 3'd6);
    pins[9] = 1'b0;
    idle(6);
    pins[9] = 1'b1;
    idle(6);
    rd(BASE + O_ST, 32'h200, "R7 matching function");
    wr(BASE + O_ST, 32'h200);

    // R8 enable gating and irq latency on line 10
    set_func(10, 3'd6);
    pins[10] = 1'b1;
    idle(6);
    rd(BASE + O_ST, 32'h400, "R8 latch while disabled");
    chk_irq(1'b0, "R8 disabled irq");
    wr(BASE + O_EN, 32'h400);
    chk_irq(1'b0, "R8 irq one cycle late");
    @(negedge clk);
    chk_irq(1'b1, "R8 irq raised");
    rd(BASE + O_EN, 32'h400, "R8 enable readback");
    wr(BASE + O_ST, 32'h400);
    chk_irq(1'b1, "R8 irq held one cycle");
    @(negedge clk);
    chk_irq(1'b0, "R8 irq dropped");

    // R10 window decode
    wr(12'h230, 32'hFFFF_FFFF);
    rd(BASE + O_EN, 32'h400, "R10 other bank write ignored");
    rd(12'h230, 32'h0, "R10 other bank read");
    rd(BASE + 12'h1C, 32'h0, "R10 unused offset");
    rd(12'h034, 32'h0, "R10 below interrupt map");

    // R9 sample-rate control
    wr(BASE + O_DB, 32'hFFFF_FFFF);
    rd(BASE + O_DB, 32'h70, "R9 select readback");
    pins[0] = 1'b0;
    idle(4);
    wr(BASE + O_DB, 32'h20);
    pins[0] = 1'b1;
    idle(5);
    rd(BASE + O_ST, 32'h0, "R9 slow sample not yet");
    rd(BASE + O_ST, 32'h1, "R9 slow sample due");
    wr(BASE + O_DB, 32'h0);
    wr(BASE + O_ST, 32'h1);
    rd(BASE + O_ST, 32'h0, "R9 cleanup");

    idle(3);
    if (sbq.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", sbq.size());
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule